// File: doc/BRIEF.md
# Camera Sensor Byte Stream Unpacker

This block sits behind the 8-bit parallel pixel port of a CMOS image sensor. The sensor's pixel clock, horizontal sync and vertical sync come into the block's own clock domain through a short synchronizer. One selectable edge of the pixel clock marks each byte. The byte is sampled only while the line sync is at its active level and the frame sync is not. Bytes gathered this way are rebuilt into whole pixels, either YCbCr 4:2:2 or RGB565, under one of four byte orders for each format.

Each pixel leaves on a valid/ready stream as three 8-bit component fields. A start-of-line flag and a start-of-frame flag travel with the pixel. A YCbCr group of four bytes makes two pixels that share one chroma pair. An RGB565 byte pair makes one pixel. In monochrome mode the chroma bytes are dropped and every luma byte becomes a pixel of its own.

The sensor cannot be stalled, so a small output queue absorbs back-pressure. When a beat is offered and not taken, the stream holds that beat unchanged until out_ready is seen high. Admission to the queue is all-or-nothing: a completed group whose pixels do not all fit into the free entries is dropped whole. Its start markers stay pending and are carried by the next pixel that is admitted.

Top module: `cam_byte_unpacker`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, out_valid is 0.
- R2: With cfg_rise_edge=1 bytes and syncs are taken on the rising pixel clock edge, with 0 on the falling edge; the bus value at the other edge has no effect on the output.
- R3: cfg_hs_high and cfg_vs_high give the active level of the line and frame syncs (1 = active high, 0 = active low).
- R4: With cfg_rgb=0, cfg_order selects the byte sequence of a group (0: Y0 U Y1 V, 1: Y0 V Y1 U, 2: U Y0 V Y1, 3: V Y0 U Y1). The group yields pixel (Y0,U,V) and then pixel (Y1,U,V), as out_c0=Y, out_c1=U, out_c2=V.
- R5: With cfg_rgb=1, a byte pair gives one pixel with out_c0={3'b0,R}, out_c1={2'b0,G}, out_c2={3'b0,B}. The byte pairs per order, as {first byte, second byte}, are: 0: {R,G[5:3]},{G[2:0],B}; 1: {B,G[5:3]},{G[2:0],R}; 2: {G[2:0],B},{R,G[5:3]}; 3: {G[2:0],R},{B,G[5:3]}.
- R6: With cfg_mono=1 and cfg_rgb=0, each luma byte of the sequence selected by R4 gives one pixel (Y,0,0), and the chroma bytes are discarded.
- R7: The byte position resets whenever the line sync is inactive, so an unfinished group at a line end is discarded and the next line starts at byte 0.
- R8: The first pixel emitted after the frame sync was sampled active carries out_sof=1, and out_sof implies out_sol.
- R9: The first pixel emitted after the line sync was sampled inactive carries out_sol=1; every other pixel has out_sol=0.
- R10: While out_valid=1 and out_ready=0 the beat holds stable. A group is admitted to the FIFO_DEPTH-entry queue only if all of its pixels fit; otherwise it is dropped whole.
- R11: Bytes sampled while the frame sync is active produce no pixel, even with the line sync active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rgb | input | 1 | 0 = YCbCr 4:2:2, 1 = RGB565 |
| cfg_order | input | 2 | Byte order code |
| cfg_rise_edge | input | 1 | 1 = sample on rising pixel clock edge, 0 = falling |
| cfg_hs_high | input | 1 | Line sync active level |
| cfg_vs_high | input | 1 | Frame sync active level |
| cfg_mono | input | 1 | Discard chroma, emit luma only |
| sen_pclk | input | 1 | Sensor pixel clock |
| sen_data | input | 8 | Sensor data bus |
| sen_hsync | input | 1 | Sensor line sync |
| sen_vsync | input | 1 | Sensor frame sync |
| out_valid | output | 1 | Pixel beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_c0 | output | 8 | Y or zero-extended R |
| out_c1 | output | 8 | U or zero-extended G |
| out_c2 | output | 8 | V or zero-extended B |
| out_sol | output | 1 | First pixel of a line |
| out_sof | output | 1 | First pixel of a frame |

## Verification
The assertions on field widths and zeroed chroma assume that the cfg_* inputs change only while the queue is empty and no line is in progress. The bench therefore sets a new configuration only after all earlier pixels have drained. They also assume that every pixel clock level, and the data and syncs around each sampling edge, last longer than the synchronizer depth. The bench holds each such phase for two block clocks. Every byte is preceded by a wrong-direction edge that carries the inverted byte, so sampling on the wrong edge shows up as corrupted pixels.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef struct packed {
    logic       sof;
    logic       sol;
    logic [7:0] c0;
    logic [7:0] c1;
    logic [7:0] c2;
  } pix_t;

  typedef struct packed {
    logic [7:0] y0;
    logic [7:0] y1;
    logic [7:0] u;
    logic [7:0] v;
  } ycc_t;

  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb_t;

  // Pull luma/chroma out of a 4-byte group; q3 is the byte arriving now.
  function automatic ycc_t ycc_split(input logic [1:0] ord, input logic [7:0] q0, q1, q2, q3);
    ycc_t s;
    case (ord)
      2'd0: begin s.y0 = q0; s.u = q1; s.y1 = q2; s.v = q3; end
      2'd1: begin s.y0 = q0; s.v = q1; s.y1 = q2; s.u = q3; end
      2'd2: begin s.u = q0; s.y0 = q1; s.v = q2; s.y1 = q3; end
      default: begin s.v = q0; s.y0 = q1; s.u = q2; s.y1 = q3; end
    endcase
    return s;
  endfunction

  // Rebuild 5/6/5 fields from a byte pair; q1 is the byte arriving now.
  function automatic rgb_t rgb_split(input logic [1:0] ord, input logic [7:0] q0, q1);
    rgb_t s;
    case (ord)
      2'd0: begin s.r = q0[7:3]; s.g = {q0[2:0], q1[7:5]}; s.b = q1[4:0]; end
      2'd1: begin s.b = q0[7:3]; s.g = {q0[2:0], q1[7:5]}; s.r = q1[4:0]; end
      2'd2: begin s.b = q0[4:0]; s.g = {q1[2:0], q0[7:5]}; s.r = q1[7:3]; end
      default: begin s.r = q0[4:0]; s.g = {q1[2:0], q0[7:5]}; s.b = q1[7:3]; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cbu_sampler.sv
module cbu_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rise_edge,
  input  logic          cfg_hs_high,
  input  logic          cfg_vs_high,
  input  logic          sen_pclk,
  input  logic [DW-1:0] sen_data,
  input  logic          sen_hsync,
  input  logic          sen_vsync,
  output logic          stb,
  output logic [DW-1:0] smp_byte,
  output logic          smp_line,
  output logic          smp_blank
);
  localparam int BUS_W = DW + 3;

  logic [SYNC_STAGES-1:0][BUS_W-1:0] stage;
  logic [BUS_W-1:0] bus_s;
  logic             pclk_prev;
  logic             edge_hit;

  // All sensor pins share the same synchronizer depth, so they stay aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[0] <= {sen_pclk, sen_hsync, sen_vsync, sen_data};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign bus_s    = stage[SYNC_STAGES-1];
  assign edge_hit = cfg_rise_edge ? (bus_s[DW+2] && !pclk_prev)
                                  : (!bus_s[DW+2] && pclk_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_prev <= 1'b0;
      stb       <= 1'b0;
      smp_byte  <= '0;
      smp_line  <= 1'b0;
      smp_blank <= 1'b0;
    end else begin
      pclk_prev <= bus_s[DW+2];
      stb       <= edge_hit;
      if (edge_hit) begin
        smp_byte  <= bus_s[DW-1:0];
        smp_line  <= (bus_s[DW+1] == cfg_hs_high);
        smp_blank <= (bus_s[DW] == cfg_vs_high);
      end
    end
  end
endmodule

// File: rtl/cbu_assembler.sv
module cbu_assembler
  import cbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rgb,
  input  logic [1:0] cfg_order,
  input  logic       cfg_mono,
  input  logic       stb,
  input  logic [7:0] smp_byte,
  input  logic       smp_line,
  input  logic       smp_blank,
  output logic [1:0] push_n,
  output pix_t       push_a,
  output pix_t       push_b,
  input  logic       push_ok
);
  logic [1:0] phase;
  logic [7:0] q0, q1, q2;
  logic       sof_pend, sol_pend;
  logic       data_beat;
  ycc_t       ys;
  rgb_t       rs;

  assign data_beat = stb && !smp_blank && smp_line;
  assign ys        = ycc_split(cfg_order, q0, q1, q2, smp_byte);
  assign rs        = rgb_split(cfg_order, q0, smp_byte);

  always_comb begin
    push_n = 2'd0;
    push_a = '0;
    push_b = '0;
    if (data_beat) begin
      if (cfg_rgb) begin
        if (phase[0]) begin
          push_n = 2'd1;
          push_a = '{sof_pend, sol_pend, {3'b000, rs.r}, {2'b00, rs.g}, {3'b000, rs.b}};
        end
      end else if (cfg_mono) begin
        // Luma sits on even bytes for orders 0/1 and on odd bytes for 2/3.
        if (phase[0] == cfg_order[1]) begin
          push_n = 2'd1;
          push_a = '{sof_pend, sol_pend, smp_byte, 8'h00, 8'h00};
        end
      end else if (phase == 2'd3) begin
        push_n = 2'd2;
        push_a = '{sof_pend, sol_pend, ys.y0, ys.u, ys.v};
        push_b = '{1'b0, 1'b0, ys.y1, ys.u, ys.v};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      q0       <= '0;
      q1       <= '0;
      q2       <= '0;
      sof_pend <= 1'b0;
      sol_pend <= 1'b0;
    end else if (stb) begin
      if (smp_blank) begin
        phase    <= 2'd0;
        sof_pend <= 1'b1;
        sol_pend <= 1'b1;
      end else if (!smp_line) begin
        phase    <= 2'd0;
        sol_pend <= 1'b1;
      end else begin
        case (phase)
          2'd0:    q0 <= smp_byte;
          2'd1:    q1 <= smp_byte;
          2'd2:    q2 <= smp_byte;
          default: ;
        endcase
        phase <= cfg_rgb ? {1'b0, ~phase[0]} : phase + 2'd1;
        if (push_n != 2'd0 && push_ok) begin
          sof_pend <= 1'b0;
          sol_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cbu_out_queue.sv
module cbu_out_queue
  import cbu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] push_n,
  input  pix_t       push_a,
  input  pix_t       push_b,
  output logic       push_ok,
  output logic       out_valid,
  input  logic       out_ready,
  output pix_t       out_pix
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pix_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, free_n;
  logic          pop, take;

  assign free_n    = CW'(DEPTH) - count;
  assign push_ok   = CW'(push_n) <= free_n;
  assign take      = (push_n != 2'd0) && push_ok;
  assign out_valid = count != '0;
  assign pop       = out_valid && out_ready;
  assign out_pix   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) begin
      mem[wr_ptr] <= push_a;
      if (push_n == 2'd2) mem[wr_ptr + AW'(1)] <= push_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (take) wr_ptr <= wr_ptr + AW'(push_n);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + (take ? CW'(push_n) : CW'(0)) - CW'(pop);
    end
  end
endmodule

// File: rtl/cam_byte_unpacker.sv
module cam_byte_unpacker
  import cbu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rgb,
  input  logic [1:0] cfg_order,
  input  logic       cfg_rise_edge,
  input  logic       cfg_hs_high,
  input  logic       cfg_vs_high,
  input  logic       cfg_mono,
  input  logic       sen_pclk,
  input  logic [7:0] sen_data,
  input  logic       sen_hsync,
  input  logic       sen_vsync,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_c0,
  output logic [7:0] out_c1,
  output logic [7:0] out_c2,
  output logic       out_sol,
  output logic       out_sof
);
  logic       stb, smp_line, smp_blank, push_ok;
  logic [7:0] smp_byte;
  logic [1:0] push_n;
  pix_t       push_a, push_b, head;

  cbu_sampler #(.SYNC_STAGES(SYNC_STAGES), .DW(8)) u_smp (
    .clk(clk), .rst_n(rst_n), .cfg_rise_edge(cfg_rise_edge),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .sen_pclk(sen_pclk), .sen_data(sen_data), .sen_hsync(sen_hsync),
    .sen_vsync(sen_vsync), .stb(stb), .smp_byte(smp_byte),
    .smp_line(smp_line), .smp_blank(smp_blank)
  );

  cbu_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .cfg_rgb(cfg_rgb), .cfg_order(cfg_order),
    .cfg_mono(cfg_mono), .stb(stb), .smp_byte(smp_byte),
    .smp_line(smp_line), .smp_blank(smp_blank), .push_n(push_n),
    .push_a(push_a), .push_b(push_b), .push_ok(push_ok)
  );

  cbu_out_queue #(.DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_a(push_a),
    .push_b(push_b), .push_ok(push_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(head)
  );

  assign out_c0  = head.c0;
  assign out_c1  = head.c1;
  assign out_c2  = head.c2;
  assign out_sol = head.sol;
  assign out_sof = head.sof;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rgb,
  input logic       cfg_mono,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_c0,
  input logic [7:0] out_c1,
  input logic [7:0] out_c2,
  input logic       out_sol,
  input logic       out_sof
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_c0, out_c1, out_c2, out_sol, out_sof}));

  // R5
  rgb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_rgb |-> out_c0[7:5] == 3'b0 && out_c1[7:6] == 2'b0 && out_c2[7:5] == 3'b0);

  // R6
  mono_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_mono && !cfg_rgb |-> out_c1 == 8'h00 && out_c2 == 8'h00);

  // R8
  sof_has_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol);
endmodule

bind cam_byte_unpacker cbu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rgb(cfg_rgb), .cfg_mono(cfg_mono),
  .out_valid(out_valid), .out_ready(out_ready), .out_c0(out_c0),
  .out_c1(out_c1), .out_c2(out_c2), .out_sol(out_sol), .out_sof(out_sof)
);

// File: tb/cam_byte_unpacker_test.sv
module cam_byte_unpacker_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rgb = 1'b0, cfg_rise_edge = 1'b1, cfg_hs_high = 1'b1, cfg_vs_high = 1'b1, cfg_mono = 1'b0;
  logic [1:0] cfg_order = 2'd0;
  logic sen_pclk = 1'b0, sen_hsync = 1'b0, sen_vsync = 1'b0;
  logic [7:0] sen_data = 8'h00;
  logic out_ready = 1'b1;
  logic out_valid, out_sol, out_sof;
  logic [7:0] out_c0, out_c1, out_c2;

  int vectors = 0, miscompares = 0;
  int n_got = 0, n_exp = 0;
  logic [25:0] got [MAXP];
  logic [25:0] exp_q [MAXP];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_byte_unpacker uut (
    .clk(clk), .rst_n(rst_n), .cfg_rgb(cfg_rgb), .cfg_order(cfg_order),
    .cfg_rise_edge(cfg_rise_edge), .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .cfg_mono(cfg_mono), .sen_pclk(sen_pclk), .sen_data(sen_data),
    .sen_hsync(sen_hsync), .sen_vsync(sen_vsync), .out_valid(out_valid),
    .out_ready(out_ready), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
    .out_sol(out_sol), .out_sof(out_sof)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && n_got < MAXP) begin
      got[n_got] = {out_sof, out_sol, out_c0, out_c1, out_c2};
      n_got++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input bit ok, input string tag, input logic [25:0] act, input logic [25:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_pix(input logic [7:0] c0, c1, c2, input bit sof, input bit sol);
    exp_q[n_exp] = {sof, sol, c0, c1, c2};
    n_exp++;
  endtask

  task automatic start_case();
    n_got = 0;
    n_exp = 0;
  endtask

  // Wrong edge with inverted bus first, then the right edge with the true byte.
  task automatic send_byte(input logic [7:0] b, input bit hs_act, input bit vs_act);
    sen_hsync = hs_act ? cfg_hs_high : !cfg_hs_high;
    sen_vsync = vs_act ? cfg_vs_high : !cfg_vs_high;
    sen_data  = ~b;
    sen_pclk  = !cfg_rise_edge;
    tick(2);
    sen_data  = b;
    tick(2);
    sen_pclk  = cfg_rise_edge;
    tick(2);
  endtask

  // R11: line sync active during frame blank must not produce pixels
  task automatic frame_blank();
    send_byte(8'h5A, 1'b1, 1'b1);
    send_byte(8'hA5, 1'b1, 1'b1);
    send_byte(8'h00, 1'b0, 1'b0);
  endtask

  task automatic line_end();
    send_byte(8'h00, 1'b0, 1'b0);
  endtask

  task automatic send_ycc(input logic [7:0] y0, u, y1, v);
    logic [31:0] w;
    case (cfg_order)
      2'd0: w = {y0, u, y1, v};
      2'd1: w = {y0, v, y1, u};
      2'd2: w = {u, y0, v, y1};
      default: w = {v, y0, u, y1};
    endcase
    for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8], 1'b1, 1'b0);
  endtask

  task automatic send_rgb(input logic [4:0] r, input logic [5:0] g, input logic [4:0] b);
    logic [15:0] w;
    case (cfg_order)
      2'd0: w = {r, g[5:3], g[2:0], b};
      2'd1: w = {b, g[5:3], g[2:0], r};
      2'd2: w = {g[2:0], b, r, g[5:3]};
      default: w = {g[2:0], r, b, g[5:3]};
    endcase
    send_byte(w[15:8], 1'b1, 1'b0);
    send_byte(w[7:0], 1'b1, 1'b0);
  endtask

  task automatic compare(input string tag);
    tick(30);
    check(n_got == n_exp, {tag, " count"}, 26'(n_got), 26'(n_exp));
    for (int i = 0; i < n_exp; i++)
      check(got[i] == exp_q[i], tag, got[i], exp_q[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    check(out_valid == 1'b0, "R1 valid low in reset", 26'(out_valid), 26'd0);
    rst_n = 1'b1;
    tick(1);
    check(out_valid == 1'b0, "R1 valid low after release", 26'(out_valid), 26'd0);
  endtask

  // R4 all orders, R3 active-high syncs, R2 rising edge, R8/R9 markers
  task automatic t_ycc_orders();
    for (int o = 0; o < 4; o++) begin
      cfg_rgb = 0; cfg_mono = 0; cfg_order = 2'(o);
      cfg_rise_edge = 1; cfg_hs_high = 1; cfg_vs_high = 1;
      start_case();
      frame_blank();
      send_ycc(8'h10 + 8'(o), 8'h80, 8'h30, 8'hC0);
      send_ycc(8'h51, 8'h22, 8'h93, 8'hE4);
      line_end();
      expect_pix(8'h10 + 8'(o), 8'h80, 8'hC0, 1, 1);
      expect_pix(8'h30, 8'h80, 8'hC0, 0, 0);
      expect_pix(8'h51, 8'h22, 8'hE4, 0, 0);
      expect_pix(8'h93, 8'h22, 8'hE4, 0, 0);
      compare("R4 ycc order R8 R9");
    end
  endtask

  // R5 all orders, R2 falling edge, R3 active-low syncs
  task automatic t_rgb_orders();
    for (int o = 0; o < 4; o++) begin
      cfg_rgb = 1; cfg_mono = 0; cfg_order = 2'(o);
      cfg_rise_edge = 0; cfg_hs_high = 0; cfg_vs_high = 0;
      start_case();
      frame_blank();
      send_rgb(5'h1F, 6'h00, 5'h01);
      send_rgb(5'h0A, 6'h2D, 5'h15);
      send_rgb(5'h03, 6'h3F, 5'h10);
      line_end();
      expect_pix(8'h1F, 8'h00, 8'h01, 1, 1);
      expect_pix(8'h0A, 8'h2D, 8'h15, 0, 0);
      expect_pix(8'h03, 8'h3F, 8'h10, 0, 0);
      compare("R5 rgb order R2 R3");
    end
  endtask

  // R6 monochrome, order 2 puts luma on bytes 1 and 3
  task automatic t_mono();
    cfg_rgb = 0; cfg_mono = 1; cfg_order = 2'd2;
    cfg_rise_edge = 1; cfg_hs_high = 1; cfg_vs_high = 0;
    start_case();
    frame_blank();
    send_ycc(8'h44, 8'h99, 8'h66, 8'hAA);
    line_end();
    expect_pix(8'h44, 8'h00, 8'h00, 1, 1);
    expect_pix(8'h66, 8'h00, 8'h00, 0, 0);
    compare("R6 mono");
    cfg_mono = 0;
  endtask

  // R11 blank bytes ignored; R7 unfinished group dropped; R9 second line marker
  task automatic t_partial_line();
    cfg_rgb = 0; cfg_mono = 0; cfg_order = 2'd0;
    cfg_rise_edge = 1; cfg_hs_high = 1; cfg_vs_high = 1;
    start_case();
    frame_blank();
    tick(30);
    check(n_got == 0, "R11 no pixel during frame blank", 26'(n_got), 26'd0);
    send_ycc(8'h01, 8'h02, 8'h03, 8'h04);
    send_byte(8'hEE, 1'b1, 1'b0);
    send_byte(8'hDD, 1'b1, 1'b0);
    line_end();
    send_ycc(8'h11, 8'h12, 8'h13, 8'h14);
    line_end();
    expect_pix(8'h01, 8'h02, 8'h04, 1, 1);
    expect_pix(8'h03, 8'h02, 8'h04, 0, 0);
    expect_pix(8'h11, 8'h12, 8'h14, 0, 1);
    expect_pix(8'h13, 8'h12, 8'h14, 0, 0);
    compare("R7 R9 line restart");
  endtask

  // R10 stall: head beat held, third group dropped with 4 entries
  task automatic t_backpressure();
    cfg_rgb = 0; cfg_mono = 0; cfg_order = 2'd1;
    cfg_rise_edge = 0; cfg_hs_high = 1; cfg_vs_high = 1;
    start_case();
    out_ready = 1'b0;
    frame_blank();
    send_ycc(8'h21, 8'h31, 8'h41, 8'h51);
    send_ycc(8'h22, 8'h32, 8'h42, 8'h52);
    send_ycc(8'h23, 8'h33, 8'h43, 8'h53);
    line_end();
    tick(5);
    check(out_valid == 1'b1, "R10 valid held under stall", 26'(out_valid), 26'd1);
    check(out_c0 == 8'h21 && out_sof == 1'b1, "R10 head beat stable",
          {out_sof, out_sol, out_c0, out_c1, out_c2}, {2'b11, 8'h21, 8'h31, 8'h51});
    out_ready = 1'b1;
    expect_pix(8'h21, 8'h31, 8'h51, 1, 1);
    expect_pix(8'h41, 8'h31, 8'h51, 0, 0);
    expect_pix(8'h22, 8'h32, 8'h52, 0, 0);
    expect_pix(8'h42, 8'h32, 8'h52, 0, 0);
    compare("R10 group drop");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_ycc_orders();
    t_rgb_orders();
    t_mono();
    t_partial_line();
    t_backpressure();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule